// File: doc/BRIEF.md
# Descriptor-Driven DMA Request Throttle

This block paces how often a DMA channel may issue requests. It sits between the descriptor fetch path and the request issue logic. Whenever the channel has a request waiting, the block answers with a one-cycle grant that allows one request. A spacing counter decides when the next grant may come.

The spacing comes from the descriptor list itself. A stride-control descriptor carries a rate value and an update flag. When the flag is set, the rate replaces the one in use and governs every request that follows, including those of chained lists, until another stride descriptor changes it. A rate of zero turns pacing off, so every pending cycle is granted. A nonzero rate N keeps grant starts at least N clock cycles apart, which protects a slow destination from congestion.

A nonzero rate that arrives while a gap is being timed does not shorten or stretch that gap; it is used at the next reload. A zero rate ends a running gap at once.

Top module: `dma_req_throttle`

## Requirements
- R1: After synchronous active-low reset the rate in use is zero and no gap is running, so a request pending in the first cycle after reset is granted in that cycle.
- R2: With the rate in use equal to zero, `req_grant` is high in every cycle in which `req_pending` is high.
- R3: A descriptor with `desc_valid` high, `desc_type` equal to 1 (stride-control) and `desc_rate_upd` high makes `desc_rate` the rate in use from the next cycle on.
- R4: A stride-control descriptor with `desc_rate_upd` low, or a descriptor of any other type (0 data, 2 link, 3 null) whatever its flag, leaves the rate in use unchanged.
- R5: With a nonzero rate N and `req_pending` held high, grants come exactly N cycles apart (N = 1 gives a grant every cycle), and never closer.
- R6: `req_grant` is never high in a cycle in which `req_pending` is low.
- R7: A nonzero rate update received while a gap is running leaves that gap's length unchanged; the new rate sets the gap after the next grant.
- R8: A rate update to zero received while a gap is running ends the gap, so a pending request is granted in the cycle after the update.
- R9: When a rate update and a grant fall in the same cycle, the gap started by that grant uses the new rate (zero giving no gap).
- R10: The rate persists across any number of data and link descriptors, so a rate set at the head of one list still paces requests issued under descriptors of a later chained list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_valid | input | 1 | A descriptor is presented this cycle |
| desc_type | input | 2 | Descriptor kind: 0 data, 1 stride-control, 2 link, 3 null |
| desc_rate | input | RATE_W (8) | Rate value carried by the descriptor |
| desc_rate_upd | input | 1 | Rate update flag of the descriptor |
| req_pending | input | 1 | The channel has a request waiting to be issued |
| req_grant | output | 1 | One request may be issued this cycle |

## Verification
The spacing counter's reload on a grant and a rate update from a stride descriptor can fall in the same cycle. The bench causes this by presenting a stride descriptor with its update flag in the very cycle that a pending request meets an expired counter. It then counts the cycles to the next grants, which must follow the new rate, both for a nonzero value and for zero. The related case of a zero update arriving in the middle of a running gap is judged by a grant appearing exactly one cycle later.

// File: rtl/dma_thr_pkg.sv
// Package: shared descriptor kind encoding for the request throttle.
// Assumes the descriptor type field is two bits wide.
package dma_thr_pkg;
    localparam int DESC_TYPE_W = 2;

    typedef enum logic [DESC_TYPE_W-1:0] {
        DESC_DATA   = 2'd0,
        DESC_STRIDE = 2'd1,
        DESC_LINK   = 2'd2,
        DESC_NULL   = 2'd3
    } desc_kind_e;
endpackage

// File: rtl/thr_desc_decode.sv
// Module: thr_desc_decode
// Picks rate updates out of the descriptor stream. Only a valid
// stride-control descriptor with its update flag set produces a strobe.
// Assumes the descriptor fields are stable while desc_valid is high.
module thr_desc_decode #(
    parameter int RATE_W = 8
) (
    input  logic                               desc_valid,
    input  logic [dma_thr_pkg::DESC_TYPE_W-1:0] desc_type,
    input  logic [RATE_W-1:0]                  desc_rate,
    input  logic                               desc_rate_upd,
    output logic                               upd_stb,
    output logic [RATE_W-1:0]                  upd_val
);
    // Purpose: qualify the update flag with descriptor kind and valid.
    always_comb begin
        upd_stb = desc_valid && desc_rate_upd &&
                  (desc_type == dma_thr_pkg::DESC_STRIDE);
        upd_val = desc_rate;
    end
endmodule

// File: rtl/thr_rate_hold.sv
// Module: thr_rate_hold
// Holds the rate in use. Loads a new value on an update strobe and
// keeps it otherwise. Assumes reset means unthrottled (rate zero).
module thr_rate_hold #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_stb,
    input  logic [RATE_W-1:0] upd_val,
    output logic [RATE_W-1:0] rate_q
);
    // Purpose: register the rate, cleared to zero by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= '0;
        end else if (upd_stb) begin
            rate_q <= upd_val;
        end
    end
endmodule

// File: rtl/thr_gap_timer.sv
// Module: thr_gap_timer
// Spacing counter and grant gate. A grant reloads the counter with
// rate-1 so grant starts are rate cycles apart; a grant is given only
// when a request is pending and the counter is zero. A same-cycle
// update is forwarded into the reload; a zero update clears the
// counter at once. Assumes rate zero and one both mean no gap.
module thr_gap_timer #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_pending,
    input  logic [RATE_W-1:0] rate_q,
    input  logic              upd_stb,
    input  logic [RATE_W-1:0] upd_val,
    output logic              req_grant
);
    localparam logic [RATE_W-1:0] ONE = RATE_W'(1);

    logic [RATE_W-1:0] gap_cnt;
    logic [RATE_W-1:0] eff_rate;
    logic              zero_upd;

    // Purpose: pick the rate that a reload in this cycle would use.
    always_comb begin
        eff_rate  = upd_stb ? upd_val : rate_q;
        zero_upd  = upd_stb && (upd_val == '0);
        req_grant = req_pending && (gap_cnt == '0);
    end

    // Purpose: run the spacing counter between grants.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= '0;
        end else if (zero_upd) begin
            gap_cnt <= '0;
        end else if (req_grant) begin
            gap_cnt <= (eff_rate == '0) ? '0 : (eff_rate - ONE);
        end else if (gap_cnt != '0) begin
            gap_cnt <= gap_cnt - ONE;
        end
    end

    AST_GAP_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant && (eff_rate > ONE)) |=> !req_grant); // R5

    AST_GAP_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        ((gap_cnt != '0) && !zero_upd) |=> (gap_cnt == $past(gap_cnt) - ONE)); // R7

    AST_ZERO_ENDS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        zero_upd |=> (gap_cnt == '0)); // R8
endmodule

// File: rtl/dma_req_throttle.sv
// Module: dma_req_throttle
// Top of the request throttle: decodes rate updates from descriptors,
// holds the rate in use and paces grants to the channel's requests.
// Assumes one descriptor per cycle at most and a request held until
// granted by the channel.
module dma_req_throttle #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    input  logic [1:0]        desc_type,
    input  logic [RATE_W-1:0] desc_rate,
    input  logic              desc_rate_upd,
    input  logic              req_pending,
    output logic              req_grant
);
    logic              upd_stb;
    logic [RATE_W-1:0] upd_val;
    logic [RATE_W-1:0] cur_rate;

    thr_desc_decode #(.RATE_W(RATE_W)) u_decode (
        .desc_valid    (desc_valid),
        .desc_type     (desc_type),
        .desc_rate     (desc_rate),
        .desc_rate_upd (desc_rate_upd),
        .upd_stb       (upd_stb),
        .upd_val       (upd_val)
    );

    thr_rate_hold #(.RATE_W(RATE_W)) u_rate (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_stb (upd_stb),
        .upd_val (upd_val),
        .rate_q  (cur_rate)
    );

    thr_gap_timer #(.RATE_W(RATE_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_pending (req_pending),
        .rate_q      (cur_rate),
        .upd_stb     (upd_stb),
        .upd_val     (upd_val),
        .req_grant   (req_grant)
    );

    AST_RATE_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && desc_rate_upd && (desc_type == 2'd1))
        |=> (cur_rate == $past(desc_rate))); // R3

    AST_RATE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !(desc_valid && desc_rate_upd && (desc_type == 2'd1))
        |=> $stable(cur_rate)); // R4

    AST_ZERO_GRANTS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && desc_rate_upd && (desc_type == 2'd1) && (desc_rate == '0))
        |=> (!req_pending || req_grant)); // R8
endmodule

// File: tb/test_dma_req_throttle.sv
// Directed bench: one task per scenario; each task checks its own grants.
module test_dma_req_throttle;
    localparam int CLK_PERIOD = 10;
    localparam int RATE_W     = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              desc_valid;
    logic [1:0]        desc_type;
    logic [RATE_W-1:0] desc_rate;
    logic              desc_rate_upd;
    logic              req_pending;
    logic              req_grant;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    dma_req_throttle #(.RATE_W(RATE_W)) i_dma_req_throttle (
        .clk           (clk),
        .rst_n         (rst_n),
        .desc_valid    (desc_valid),
        .desc_type     (desc_type),
        .desc_rate     (desc_rate),
        .desc_rate_upd (desc_rate_upd),
        .req_pending   (req_pending),
        .req_grant     (req_grant)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit got, input bit exp, input string tag, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: grant=%0b expected %0b", tag, what, got, exp);
        end
    endtask

    // One cycle: drive at the falling edge, then sample the grant.
    task automatic tick(input bit pend, input bit dv, input logic [1:0] dt,
                        input int rate, input bit upd, output bit g);
        @(negedge clk);
        req_pending   = pend;
        desc_valid    = dv;
        desc_type     = dt;
        desc_rate     = RATE_W'(rate);
        desc_rate_upd = upd;
        #1 g = req_grant;
    endtask

    task automatic idle(input int n, input string tag);
        bit g;
        for (int i = 0; i < n; i++) begin
            tick(1'b0, 1'b0, 2'd0, 0, 1'b0, g);
            check(g, 1'b0, tag, "grant without pending");
        end
    endtask

    task automatic set_rate(input int r, input string tag);
        bit g;
        tick(1'b0, 1'b1, 2'd1, r, 1'b1, g);
        check(g, 1'b0, tag, "grant while loading rate");
    endtask

    // Holds pending for len cycles starting with an expired counter.
    task automatic pattern(input int r, input int len, input string tag);
        bit g;
        for (int i = 0; i < len; i++) begin
            tick(1'b1, 1'b0, 2'd0, 0, 1'b0, g);
            check(g, (r <= 1) ? 1'b1 : ((i % r) == 0), tag, $sformatf("rate %0d cycle %0d", r, i));
        end
    endtask

    task automatic t_reset();
        bit g;
        rst_n = 1'b0;
        tick(1'b0, 1'b0, 2'd0, 0, 1'b0, g);
        tick(1'b0, 1'b0, 2'd0, 0, 1'b0, g);
        @(negedge clk);
        rst_n = 1'b1;
        tick(1'b1, 1'b0, 2'd0, 0, 1'b0, g);
        check(g, 1'b1, "R1", "first pending after reset");
    endtask

    task automatic t_unthrottled();
        pattern(0, 6, "R2");
        idle(2, "R6");
    endtask

    task automatic t_rates();
        int rl[4] = '{1, 2, 3, 8};
        foreach (rl[k]) begin
            set_rate(rl[k], "R3");
            idle(rl[k] + 1, "R6");
            pattern(rl[k], 3 * rl[k] + 1, "R5");
            idle(rl[k] + 1, "R6");
        end
    endtask

    task automatic t_ignore();
        bit g;
        set_rate(4, "R3");
        tick(1'b0, 1'b1, 2'd1, 0, 1'b0, g);
        tick(1'b0, 1'b1, 2'd0, 0, 1'b1, g);
        tick(1'b0, 1'b1, 2'd2, 9, 1'b1, g);
        tick(1'b0, 1'b1, 2'd3, 0, 1'b1, g);
        idle(5, "R6");
        pattern(4, 12, "R4");
        idle(5, "R6");
    endtask

    task automatic t_mid_update();
        bit g;
        set_rate(6, "R3");
        idle(7, "R6");
        for (int i = 0; i < 13; i++) begin
            tick(1'b1, i == 2, 2'd1, 3, i == 2, g);
            check(g, (i == 0) || (i == 6) || (i == 9) || (i == 12), "R7",
                  $sformatf("cycle %0d", i));
        end
        idle(4, "R6");
    endtask

    task automatic t_zero_update();
        bit g;
        set_rate(10, "R3");
        idle(11, "R6");
        for (int i = 0; i < 6; i++) begin
            tick(1'b1, i == 3, 2'd1, 0, i == 3, g);
            check(g, (i == 0) || (i >= 4), "R8", $sformatf("cycle %0d", i));
        end
        idle(2, "R6");
    endtask

    task automatic t_same_cycle();
        bit g;
        set_rate(8, "R3");
        idle(9, "R6");
        for (int i = 0; i < 8; i++) begin
            tick(1'b1, i == 0, 2'd1, 3, i == 0, g);
            check(g, (i % 3) == 0, "R9", $sformatf("nonzero cycle %0d", i));
        end
        idle(4, "R6");
        set_rate(7, "R3");
        idle(8, "R6");
        for (int i = 0; i < 4; i++) begin
            tick(1'b1, i == 0, 2'd1, 0, i == 0, g);
            check(g, 1'b1, "R9", $sformatf("zero cycle %0d", i));
        end
        idle(2, "R6");
    endtask

    task automatic t_chain();
        bit g;
        set_rate(5, "R3");
        idle(6, "R6");
        for (int i = 0; i < 16; i++) begin
            tick(1'b1, 1'b1, (i % 3 == 1) ? 2'd2 : 2'd0, 0, 1'b1, g);
            check(g, (i % 5) == 0, "R10", $sformatf("cycle %0d", i));
        end
        idle(6, "R6");
    endtask

    initial begin
        rst_n = 1'b0; desc_valid = 1'b0; desc_type = 2'd0;
        desc_rate = '0; desc_rate_upd = 1'b0; req_pending = 1'b0;
        t_reset();
        t_unthrottled();
        t_rates();
        t_ignore();
        t_mid_update();
        t_zero_update();
        t_same_cycle();
        t_chain();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule